// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block decides when a small processor system may go to sleep or stop mode, and how it comes back. The CPU signals that it has executed a wait-for-interrupt instruction. Three control bits qualify that request: deep-sleep, sleep-on-exit and regulator low-power select. A sleep request only gates the core clocks. A stop request also shuts down the PLL, the external high-speed oscillator and the internal high-speed RC oscillator, and it may put the voltage regulator into low-power mode.

Stop entry waits in a pending state until the flash programming unit and the peripheral bus both report idle. A wakeup event seen during that wait cancels the entry. When the block leaves stop mode, it first restarts the internal RC oscillator. The core clocks are released only once that oscillator reports ready. At that point the system clock selection is forced to the internal RC oscillator and the PLL and external oscillator enables are cleared. A one-cycle pulse marks each exit from stop mode. The block issues no reset of any kind, so all register and memory state survives.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `mode` is 0, `core_clk_en` and `hsi_en` are 1, `pll_en`, `hse_en`, `reg_lowpwr` and `stop_exit_pulse` are 0, and `sys_clk_sel` is 0, the code for the internal RC oscillator. The mode codes are RUN=0, PENDING=1, SLEEP=2, STOP=3 and WAKE=4.
- R2: A `cfg_wr` strobe loads `cfg_sel`, `cfg_pll` and `cfg_hse` into the clock configuration only in RUN; in any other mode the strobe has no effect.
- R3: In RUN, `wfi_req` with `deep_sel`=0 and `sleep_on_exit`=1 enters SLEEP. In SLEEP `core_clk_en` is 0 and the oscillator and PLL enables keep their configured values. `wake_evt` returns the block to RUN and leaves the clock selection unchanged.
- R4: In RUN, `wfi_req` with both `deep_sel` and `sleep_on_exit` at 0 is ignored.
- R5: In RUN, `wfi_req` with `deep_sel`=1 enters PENDING, where core clocks keep running. PENDING moves to STOP only on an edge where `flash_busy` and `bus_busy` are both 0.
- R6: In STOP, `core_clk_en`, `pll_en`, `hse_en` and `hsi_en` are all 0.
- R7: `reg_lowpwr` is 1 in STOP and WAKE only if `lp_reg_sel` was 1 on the edge that entered STOP; it is 0 in every other case.
- R8: `wake_evt` in STOP enters WAKE, where `hsi_en` is 1 and core clocks stay gated. The block leaves WAKE for RUN on the first edge with `hsi_ready`=1.
- R9: On the move from WAKE to RUN, `sys_clk_sel` becomes 0 and the PLL and external oscillator configuration bits are cleared, so both enables stay 0 in RUN.
- R10: `stop_exit_pulse` is 1 for exactly the one cycle after each move from WAKE to RUN.
- R11: `wake_evt` in PENDING cancels the entry and returns the block straight to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | CPU executed wait-for-interrupt |
| deep_sel | input | 1 | Deep-sleep control bit |
| sleep_on_exit | input | 1 | Sleep-on-exit control bit |
| lp_reg_sel | input | 1 | Regulator low-power select for stop |
| flash_busy | input | 1 | Flash program operation in progress |
| bus_busy | input | 1 | Peripheral-bus access outstanding |
| wake_evt | input | 1 | Interrupt or wakeup event |
| hsi_ready | input | 1 | Internal RC oscillator stable |
| cfg_wr | input | 1 | Clock configuration write strobe |
| cfg_sel | input | SEL_W | System clock selection to load |
| cfg_pll | input | 1 | PLL enable to load |
| cfg_hse | input | 1 | External oscillator enable to load |
| mode | output | 3 | Current mode code |
| core_clk_en | output | 1 | Core-domain clock enable |
| hsi_en | output | 1 | Internal RC oscillator enable |
| pll_en | output | 1 | PLL enable |
| hse_en | output | 1 | External oscillator enable |
| reg_lowpwr | output | 1 | Regulator in low-power mode |
| sys_clk_sel | output | SEL_W | System clock selection |
| stop_exit_pulse | output | 1 | One-cycle pulse on stop exit |

## Verification
Every output is registered from the next mode, so a wrong state shows at `mode` and at the clock-gate outputs on the very edge where it is taken. A stop entered too early shows as `mode`=3 while a busy input is still high. A wrong exit path shows in the cycle of the exit as `stop_exit_pulse` missing or `sys_clk_sel` not at 0. Stale PLL or external oscillator configuration shows as an enable that comes back in the first RUN cycle after WAKE.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_PEND  = 3'd1,
    M_SLEEP = 3'd2,
    M_STOP  = 3'd3,
    M_WAKE  = 3'd4
  } lpm_mode_e;
endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wfi_req,
  input  logic      deep_sel,
  input  logic      sleep_on_exit,
  input  logic      flash_busy,
  input  logic      bus_busy,
  input  logic      wake_evt,
  input  logic      hsi_ready,
  output lpm_mode_e mode_q,
  output lpm_mode_e mode_d
);
  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_RUN: begin
        if (wfi_req && deep_sel)           mode_d = M_PEND;
        else if (wfi_req && sleep_on_exit) mode_d = M_SLEEP;
      end
      M_PEND: begin
        if (wake_evt)                      mode_d = M_RUN;
        else if (!flash_busy && !bus_busy) mode_d = M_STOP;
      end
      M_SLEEP: if (wake_evt)  mode_d = M_RUN;
      M_STOP:  if (wake_evt)  mode_d = M_WAKE;
      M_WAKE:  if (hsi_ready) mode_d = M_RUN;
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_RUN;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/lpm_outs.sv
module lpm_outs
  import lpm_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int HSI_SEL = 0
)(
  input  logic             clk,
  input  logic             rst,
  input  lpm_mode_e        mode_q,
  input  lpm_mode_e        mode_d,
  input  logic             lp_reg_sel,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_pll,
  input  logic             cfg_hse,
  output logic             core_clk_en,
  output logic             hsi_en,
  output logic             pll_en,
  output logic             hse_en,
  output logic             reg_lowpwr,
  output logic [SEL_W-1:0] sys_clk_sel,
  output logic             stop_exit_pulse
);
  localparam logic [SEL_W-1:0] SEL_RESET = SEL_W'(HSI_SEL);

  logic [SEL_W-1:0] sel_q, sel_n;
  logic             pll_q, pll_n, hse_q, hse_n, lp_q, lp_n;
  logic             leave_stop, osc_gated, core_on;

  always_comb begin
    leave_stop = (mode_q == M_WAKE) && (mode_d == M_RUN);
    osc_gated  = (mode_d == M_STOP) || (mode_d == M_WAKE);
    core_on    = (mode_d == M_RUN)  || (mode_d == M_PEND);
    sel_n = sel_q;
    pll_n = pll_q;
    hse_n = hse_q;
    if (leave_stop) begin
      sel_n = SEL_RESET;
      pll_n = 1'b0;
      hse_n = 1'b0;
    end else if (cfg_wr && mode_q == M_RUN) begin
      sel_n = cfg_sel;
      pll_n = cfg_pll;
      hse_n = cfg_hse;
    end
    lp_n = (mode_q == M_PEND && mode_d == M_STOP) ? lp_reg_sel : lp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q           <= SEL_RESET;
      pll_q           <= 1'b0;
      hse_q           <= 1'b0;
      lp_q            <= 1'b0;
      core_clk_en     <= 1'b1;
      hsi_en          <= 1'b1;
      pll_en          <= 1'b0;
      hse_en          <= 1'b0;
      reg_lowpwr      <= 1'b0;
      sys_clk_sel     <= SEL_RESET;
      stop_exit_pulse <= 1'b0;
    end else begin
      sel_q           <= sel_n;
      pll_q           <= pll_n;
      hse_q           <= hse_n;
      lp_q            <= lp_n;
      core_clk_en     <= core_on;
      hsi_en          <= (mode_d != M_STOP);
      pll_en          <= pll_n && !osc_gated;
      hse_en          <= hse_n && !osc_gated;
      reg_lowpwr      <= lp_n && osc_gated;
      sys_clk_sel     <= sel_n;
      stop_exit_pulse <= leave_stop;
    end
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int HSI_SEL = 0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic             deep_sel,
  input  logic             sleep_on_exit,
  input  logic             lp_reg_sel,
  input  logic             flash_busy,
  input  logic             bus_busy,
  input  logic             wake_evt,
  input  logic             hsi_ready,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_pll,
  input  logic             cfg_hse,
  output logic [2:0]       mode,
  output logic             core_clk_en,
  output logic             hsi_en,
  output logic             pll_en,
  output logic             hse_en,
  output logic             reg_lowpwr,
  output logic [SEL_W-1:0] sys_clk_sel,
  output logic             stop_exit_pulse
);
  lpm_mode_e mode_q, mode_d;

  lpm_fsm u_fsm (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .deep_sel(deep_sel),
    .sleep_on_exit(sleep_on_exit), .flash_busy(flash_busy), .bus_busy(bus_busy),
    .wake_evt(wake_evt), .hsi_ready(hsi_ready), .mode_q(mode_q), .mode_d(mode_d)
  );

  lpm_outs #(.SEL_W(SEL_W), .HSI_SEL(HSI_SEL)) u_outs (
    .clk(clk), .rst(rst), .mode_q(mode_q), .mode_d(mode_d),
    .lp_reg_sel(lp_reg_sel), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_pll(cfg_pll), .cfg_hse(cfg_hse), .core_clk_en(core_clk_en),
    .hsi_en(hsi_en), .pll_en(pll_en), .hse_en(hse_en), .reg_lowpwr(reg_lowpwr),
    .sys_clk_sel(sys_clk_sel), .stop_exit_pulse(stop_exit_pulse)
  );

  assign mode = mode_q;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int SEL_W   = 2,
  parameter int HSI_SEL = 0
)(
  input logic             clk,
  input logic             rst,
  input logic             flash_busy,
  input logic             bus_busy,
  input logic             wake_evt,
  input logic [2:0]       mode,
  input logic             core_clk_en,
  input logic             hsi_en,
  input logic             pll_en,
  input logic             hse_en,
  input logic             reg_lowpwr,
  input logic [SEL_W-1:0] sys_clk_sel,
  input logic             stop_exit_pulse
);
  p_stop_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) |-> (!core_clk_en && !hsi_en && !pll_en && !hse_en));

  p_stop_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && $past(mode) == 3'd1) |-> (!$past(flash_busy) && !$past(bus_busy)));

  p_lowpwr_scope_r7: assert property (@(posedge clk) disable iff (rst)
    reg_lowpwr |-> (mode == 3'd3 || mode == 3'd4));

  p_exit_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    stop_exit_pulse |-> (mode == 3'd0 && $past(mode) == 3'd4));

  p_exit_clean_r9: assert property (@(posedge clk) disable iff (rst)
    stop_exit_pulse |-> (sys_clk_sel == SEL_W'(HSI_SEL) && !pll_en && !hse_en));

  p_wake_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> (hsi_en && !core_clk_en));

  p_cancel_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 3'd1 && $past(wake_evt)) |-> (mode == 3'd0));
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.SEL_W(SEL_W), .HSI_SEL(HSI_SEL)) u_chk (
  .clk(clk), .rst(rst), .flash_busy(flash_busy), .bus_busy(bus_busy),
  .wake_evt(wake_evt), .mode(mode), .core_clk_en(core_clk_en), .hsi_en(hsi_en),
  .pll_en(pll_en), .hse_en(hse_en), .reg_lowpwr(reg_lowpwr),
  .sys_clk_sel(sys_clk_sel), .stop_exit_pulse(stop_exit_pulse)
);

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wfi_req = 0, deep_sel = 0, sleep_on_exit = 0, lp_reg_sel = 0;
  logic       flash_busy = 0, bus_busy = 0, wake_evt = 0, hsi_ready = 0;
  logic       cfg_wr = 0, cfg_pll = 0, cfg_hse = 0;
  logic [1:0] cfg_sel = 0;
  logic [2:0] mode;
  logic       core_clk_en, hsi_en, pll_en, hse_en, reg_lowpwr, stop_exit_pulse;
  logic [1:0] sys_clk_sel;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  lpm_sequencer uut (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .deep_sel(deep_sel),
    .sleep_on_exit(sleep_on_exit), .lp_reg_sel(lp_reg_sel), .flash_busy(flash_busy),
    .bus_busy(bus_busy), .wake_evt(wake_evt), .hsi_ready(hsi_ready), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_pll(cfg_pll), .cfg_hse(cfg_hse), .mode(mode),
    .core_clk_en(core_clk_en), .hsi_en(hsi_en), .pll_en(pll_en), .hse_en(hse_en),
    .reg_lowpwr(reg_lowpwr), .sys_clk_sel(sys_clk_sel), .stop_exit_pulse(stop_exit_pulse)
  );

  // inputs {wfi,deep,soe,lp,fbusy,bbusy,wake,rdy}, mode, {core,hsi,pll,reg,pulse}
  localparam logic [15:0] VEC [13] = '{
    {8'b10100000, 3'd2, 5'b01100},  // R3 sleep entry
    {8'b00000000, 3'd2, 5'b01100},  // R3 stays asleep
    {8'b00000010, 3'd0, 5'b11100},  // R3 wake from sleep
    {8'b10000000, 3'd0, 5'b11100},  // R4 plain wfi ignored
    {8'b11011000, 3'd1, 5'b11100},  // R5 pending, flash busy
    {8'b00001000, 3'd1, 5'b11100},  // R5 flash still busy
    {8'b00000100, 3'd1, 5'b11100},  // R5 bus busy
    {8'b00010000, 3'd3, 5'b00010},  // R6 R7 stop with low-power regulator
    {8'b00000000, 3'd3, 5'b00010},  // R6 stays stopped
    {8'b00000010, 3'd4, 5'b01010},  // R8 wake begins
    {8'b00000000, 3'd4, 5'b01010},  // R8 waits for ready
    {8'b00000001, 3'd0, 5'b11001},  // R9 R10 exit with pulse
    {8'b00000000, 3'd0, 5'b11000}   // R10 pulse ends
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    {wfi_req, deep_sel, sleep_on_exit, lp_reg_sel, flash_busy, bus_busy, wake_evt, hsi_ready} = v;
    @(negedge clk);
    {wfi_req, deep_sel, sleep_on_exit, lp_reg_sel, flash_busy, bus_busy, wake_evt, hsi_ready} = '0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic p, input logic h);
    cfg_wr = 1; cfg_sel = s; cfg_pll = p; cfg_hse = h;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 mode", mode, 0);
    chk("R1 gates", {core_clk_en, hsi_en, pll_en, hse_en, reg_lowpwr, stop_exit_pulse}, 6'b110000);
    chk("R1 sel", sys_clk_sel, 0);

    cfg(2'd2, 1, 1);
    chk("R2 load in run", {sys_clk_sel, pll_en, hse_en}, 4'b1011);

    for (int i = 0; i < 13; i++) begin
      apply(VEC[i][15:8]);
      chk($sformatf("R3-table row %0d mode", i), mode, VEC[i][7:5]);
      chk($sformatf("R6-table row %0d outs", i),
          {core_clk_en, hsi_en, pll_en, reg_lowpwr, stop_exit_pulse}, VEC[i][4:0]);
    end
    chk("R9 sel forced", sys_clk_sel, 0);
    chk("R9 hse off", hse_en, 0);

    // R7 stop with normal regulator; R2 write ignored while stopped
    apply(8'b11000000);
    apply(8'b00000000);
    chk("R7 normal regulator", {mode, reg_lowpwr}, {3'd3, 1'b0});
    cfg(2'd2, 1, 0);
    apply(8'b00000010);
    apply(8'b00000001);
    chk("R2 ignored in stop", {mode, sys_clk_sel, pll_en}, {3'd0, 2'd0, 1'b0});

    // R11 cancel during pending
    apply(8'b11001000);
    chk("R11 pending", mode, 1);
    apply(8'b00001010);
    chk("R11 cancel", {mode, core_clk_en, stop_exit_pulse}, {3'd0, 1'b1, 1'b0});

    cfg(2'd1, 0, 1);
    chk("R2 second load", {sys_clk_sel, hse_en}, {2'd1, 1'b1});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule